// File: doc/BRIEF.md
# Perceptron Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of weight rows, one small perceptron per row. A hash of the fetch PC selects a row. A bias weight plus one weight for each bit of a global outcome history form a signed sum. History bits count as +1 when taken and -1 when not taken. The sign of that sum is the guess. The sum and the guess come out combinationally from the registered table and history.

When a branch resolves, the pipeline returns the branch PC, the real outcome, the sum the block produced for it, and the history snapshot it saw at prediction time. The block trains the selected row with the perceptron rule, but only if the guess was wrong or the sum sat inside the confidence band ±THETA. Weights saturate and never wrap. In the same cycle the block shifts the resolved outcome into its own global history register. That register is an output so the front end can keep a snapshot beside each in-flight branch.

Top module: `perc_predictor`

## Requirements
- R1: After reset every weight is zero and the history register is all zeros, so every lookup returns sum 0, predicts taken, and shows history 0.
- R2: The row index is PC bits [IDX_W+1:2] XOR PC bits [2*IDX_W+1:IDX_W+2], with IDX_W = log2(ROWS). Two PCs with equal index share one row.
- R3: The sum is w0 plus, for each history bit i (bit 0 newest), +w(i+1) when the bit is 1 and -w(i+1) when it is 0. It is given as a signed value on pred_sum.
- R4: pred_taken is 1 exactly when pred_sum is greater than or equal to zero.
- R5: An update trains only if (up_sum >= 0) differs from up_taken, or if -THETA <= up_sum <= THETA. Otherwise the row's weights stay unchanged.
- R6: Training adds t to w0 and t·x_i to w(i+1), where t is +1 for taken and -1 for not taken, and x_i is the bipolar value of up_hist bit i. The history used is up_hist, not the current register.
- R7: Weights are W_BITS-bit signed values (default 8). A step that would go past +127 or below -128 leaves the weight at that limit.
- R8: Each update shifts up_taken into history bit 0 and moves older bits up by one, dropping the oldest. Without an update the history holds.
- R9: A trained row is seen by lookups from the cycle after the update edge. Rows with another index are unchanged.
- R10: THETA defaults to floor(1.93·HIST_LEN + 14), which is 29 for the default HIST_LEN of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_pc | input | PC_W | Lookup PC |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_sum | output | SUM_W | Signed perceptron output for lk_pc |
| pred_hist | output | HIST_LEN | Current global history (bit 0 newest, 1 = taken) |
| up_valid | input | 1 | Resolved-branch update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome (1 = taken) |
| up_sum | input | SUM_W | Sum produced when that branch was predicted |
| up_hist | input | HIST_LEN | History snapshot taken at prediction time |

## Verification
The bench probes the edges of the confidence band. A correct guess with a sum of exactly THETA must train, and one with THETA+1 must not. A design with an off-by-one band would drift or freeze weights. It also supplies a snapshot history that differs from the live register, which catches a design that trains on the wrong history. Long runs of identical outcomes drive every weight to both limits, where a wrapping adder would flip the sign of the sum. Aliasing and non-aliasing PCs show whether the hash and the row write are confined to the right row.

// File: rtl/perc_pkg.sv
package perc_pkg;

  // Bipolar value of one history or outcome bit.
  function automatic int bipolar(input logic b);
    return b ? 1 : -1;
  endfunction

  // One saturating training step on a weight.
  function automatic int sat_step(input int w, input int step, input int wmin, input int wmax);
    int r;
    r = w + step;
    if (r > wmax) r = wmax;
    if (r < wmin) r = wmin;
    return r;
  endfunction

  // Default confidence threshold: floor(1.93*n + 14).
  function automatic int default_theta(input int n);
    return (193 * n + 1400) / 100;
  endfunction

endpackage

// File: rtl/perc_weight_store.sv
module perc_weight_store #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 72,
  localparam int IDX_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [ROW_W-1:0] rd_a_row,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [ROW_W-1:0] rd_b_row,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ROW_W-1:0] wr_row
);

  logic [ROW_W-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (we) begin
      mem[wr_idx] <= wr_row;
    end
  end

  assign rd_a_row = mem[rd_a_idx];
  assign rd_b_row = mem[rd_b_idx];

  // R5/R9: with no write, a steady read address returns a steady row.
  a_r5_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(we) && $stable(rd_a_idx)) |-> $stable(rd_a_row));

endmodule

// File: rtl/perc_dot.sv
module perc_dot #(
  parameter int HIST_LEN = 8,
  parameter int W_BITS   = 8,
  parameter int SUM_W    = 13,
  localparam int NW      = HIST_LEN + 1,
  localparam int ROW_W   = NW * W_BITS
) (
  input  logic [ROW_W-1:0]        row,
  input  logic [HIST_LEN-1:0]     hist,
  output logic signed [SUM_W-1:0] sum
);

  logic signed [SUM_W-1:0] wext [NW];

  for (genvar k = 0; k < NW; k++) begin : g_ext
    assign wext[k] = SUM_W'($signed(row[k*W_BITS +: W_BITS]));
  end

  always_comb begin
    sum = wext[0];
    for (int i = 0; i < HIST_LEN; i++) begin
      if (hist[i]) sum = sum + wext[i+1];
      else         sum = sum - wext[i+1];
    end
  end

endmodule

// File: rtl/perc_trainer.sv
module perc_trainer #(
  parameter int HIST_LEN = 8,
  parameter int W_BITS   = 8,
  parameter int SUM_W    = 13,
  parameter int THETA    = 29,
  localparam int NW      = HIST_LEN + 1,
  localparam int ROW_W   = NW * W_BITS,
  localparam int WMAX    = (1 << (W_BITS - 1)) - 1,
  localparam int WMIN    = -(1 << (W_BITS - 1))
) (
  input  logic [ROW_W-1:0]        row_old,
  input  logic [HIST_LEN-1:0]     hist,
  input  logic                    taken,
  input  logic signed [SUM_W-1:0] sum,
  output logic [ROW_W-1:0]        row_new,
  output logic                    mispredict,
  output logic                    low_conf,
  output logic                    train
);
  import perc_pkg::*;

  localparam logic signed [SUM_W-1:0] THETA_P = SUM_W'(THETA);
  localparam logic signed [SUM_W-1:0] THETA_N = -SUM_W'(THETA);

  assign mispredict = (sum >= 0) != taken;
  assign low_conf   = (sum <= THETA_P) && (sum >= THETA_N);
  assign train      = mispredict || low_conf;

  // Bias weight: its input is always +1.
  always_comb begin
    row_new[W_BITS-1:0] = W_BITS'(sat_step(int'($signed(row_old[W_BITS-1:0])),
                                           bipolar(taken), WMIN, WMAX));
  end

  for (genvar i = 0; i < HIST_LEN; i++) begin : g_w
    always_comb begin
      row_new[(i+1)*W_BITS +: W_BITS] =
        W_BITS'(sat_step(int'($signed(row_old[(i+1)*W_BITS +: W_BITS])),
                         bipolar(taken) * bipolar(hist[i]), WMIN, WMAX));
    end
  end

endmodule

// File: rtl/perc_predictor.sv
module perc_predictor #(
  parameter int PC_W     = 32,
  parameter int ROWS     = 16,
  parameter int HIST_LEN = 8,
  parameter int W_BITS   = 8,
  parameter int THETA    = perc_pkg::default_theta(HIST_LEN),
  localparam int IDX_W   = $clog2(ROWS),
  localparam int NW      = HIST_LEN + 1,
  localparam int ROW_W   = NW * W_BITS,
  localparam int SUM_W   = W_BITS + $clog2(NW) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PC_W-1:0]         lk_pc,
  output logic                    pred_taken,
  output logic signed [SUM_W-1:0] pred_sum,
  output logic [HIST_LEN-1:0]     pred_hist,
  input  logic                    up_valid,
  input  logic [PC_W-1:0]         up_pc,
  input  logic                    up_taken,
  input  logic signed [SUM_W-1:0] up_sum,
  input  logic [HIST_LEN-1:0]     up_hist
);

  function automatic logic [IDX_W-1:0] row_hash(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2] ^ pc[2*IDX_W+1:IDX_W+2];
  endfunction

  logic [IDX_W-1:0]    lk_idx, up_idx;
  logic [ROW_W-1:0]    lk_row, up_row_old, up_row_new;
  logic                trn_mispredict, trn_low_conf, trn_fire, row_we;
  logic [HIST_LEN-1:0] ghr;

  assign lk_idx = row_hash(lk_pc);
  assign up_idx = row_hash(up_pc);

  perc_weight_store #(.ROWS(ROWS), .ROW_W(ROW_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(lk_idx), .rd_a_row(lk_row),
    .rd_b_idx(up_idx), .rd_b_row(up_row_old),
    .we(row_we), .wr_idx(up_idx), .wr_row(up_row_new)
  );

  perc_dot #(.HIST_LEN(HIST_LEN), .W_BITS(W_BITS), .SUM_W(SUM_W)) u_dot (
    .row(lk_row), .hist(ghr), .sum(pred_sum)
  );

  perc_trainer #(.HIST_LEN(HIST_LEN), .W_BITS(W_BITS), .SUM_W(SUM_W), .THETA(THETA)) u_trn (
    .row_old(up_row_old), .hist(up_hist), .taken(up_taken), .sum(up_sum),
    .row_new(up_row_new), .mispredict(trn_mispredict), .low_conf(trn_low_conf),
    .train(trn_fire)
  );

  assign row_we     = up_valid && trn_fire;
  assign pred_taken = !pred_sum[SUM_W-1];
  assign pred_hist  = ghr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghr <= '0;
    else if (up_valid) ghr <= {ghr[HIST_LEN-2:0], up_taken};
  end

  // R8: history shift on update, hold otherwise.
  a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> pred_hist == {$past(pred_hist[HIST_LEN-2:0]), $past(up_taken)});
  a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(pred_hist));

  // R5: a confident correct guess never writes the table.
  a_r5_no_train: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !trn_mispredict && !trn_low_conf) |-> !row_we);

  // R6/R7: each weight moves by at most one step and never wraps.
  for (genvar k = 0; k < NW; k++) begin : g_chk
    logic signed [W_BITS-1:0] w_o, w_n;
    logic signed [W_BITS:0]   w_d;
    assign w_o = up_row_old[k*W_BITS +: W_BITS];
    assign w_n = up_row_new[k*W_BITS +: W_BITS];
    assign w_d = {w_n[W_BITS-1], w_n} - {w_o[W_BITS-1], w_o};
    a_r6_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (w_d >= -1 && w_d <= 1));
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> ($signed({w_o[W_BITS-1], w_o}) * $signed({w_n[W_BITS-1], w_n}) >= 0
                    || w_o == 0 || w_n == 0));
  end

endmodule

// File: tb/perc_predictor_tb.sv
module perc_predictor_tb;
  localparam int PC_W = 32, ROWS = 16, HL = 8, WB = 8, NW = HL + 1;
  localparam int SUM_W = 13, THETA = 29, IDX_W = 4;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic pred_taken, up_valid = 0, up_taken = 0;
  logic signed [SUM_W-1:0] pred_sum, up_sum = '0;
  logic [HL-1:0] pred_hist, up_hist = '0;

  int n_chk = 0, n_bad = 0;
  int wm [ROWS][NW];
  int ghr_m = 0;

  always #4 clk = ~clk;

  perc_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_sum(pred_sum), .pred_hist(pred_hist), .up_valid(up_valid),
    .up_pc(up_pc), .up_taken(up_taken), .up_sum(up_sum), .up_hist(up_hist)
  );

  function automatic int hidx(input logic [PC_W-1:0] pc);
    return int'((pc >> 2) % ROWS) ^ int'((pc >> (2 + IDX_W)) % ROWS);
  endfunction

  function automatic int msum(input int r, input int h);
    int s = wm[r][0];
    for (int i = 0; i < HL; i++) s += ((h >> i) & 1) ? wm[r][i+1] : -wm[r][i+1];
    return s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(input logic [PC_W-1:0] pc, input string req);
    int e;
    @(negedge clk); lk_pc = pc; #1;
    e = msum(hidx(pc), ghr_m);
    check(req, int'(pred_sum), e);
    check({req, " R4"}, int'(pred_taken), (e >= 0) ? 1 : 0);
    check({req, " R8 hist"}, int'(pred_hist), ghr_m);
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input bit tk, input int s, input int h);
    int r, t;
    @(negedge clk);
    up_pc = pc; up_taken = tk; up_sum = SUM_W'(s); up_hist = HL'(h); up_valid = 1;
    @(posedge clk);
    r = hidx(pc); t = tk ? 1 : -1;
    if (((s >= 0) != tk) || (s <= THETA && s >= -THETA)) begin
      wm[r][0] = wm[r][0] + t > 127 ? 127 : (wm[r][0] + t < -128 ? -128 : wm[r][0] + t);
      for (int i = 0; i < HL; i++) begin
        int v = wm[r][i+1] + (((h >> i) & 1) ? t : -t);
        wm[r][i+1] = v > 127 ? 127 : (v < -128 ? -128 : v);
      end
    end
    ghr_m = ((ghr_m << 1) | (tk ? 1 : 0)) & ((1 << HL) - 1);
    #1 up_valid = 0;
  endtask

  task automatic t_reset;
    look(32'h0000_0000, "R1 zero sum");
    look(32'h1234_5678, "R1 zero sum other pc");
    check("R1 taken", int'(pred_taken), 1);
  endtask

  task automatic t_basic;
    // Low-confidence not-taken training on row of 0x40 (R5, R6, R3).
    upd(32'h0000_0040, 0, 0, 'hA5);
    look(32'h0000_0040, "R6 trained row");
    upd(32'h0000_0040, 1, -3, 'h3C);
    look(32'h0000_0040, "R3 sum after two steps");
    look(32'h0000_0080, "R9 other row untouched");
  endtask

  task automatic t_alias;
    // 0x04 -> idx 1; 0x44 -> bits[5:2]=1 ^ bits[9:6]=1 -> 0; 0x0044|0x100? use 0x0144 -> 1^5=4.
    // 0x0044 ^ ... alias pair: 0x004 (1^0=1) and 0x0000_0800? bits[9:6]=0x20>>? pick 0x0000_0148 -> 2^5=7.
    upd(32'h0000_0004, 1, 0, 'hFF);
    look(32'h0000_0004, "R2 trained pc");
    look(32'h0000_00C0, "R2 alias pc 0xC0 (0^3=3 differs)");
    look(32'h0000_0048, "R2 alias pc 0x48 (2^1=3)");
    look(32'h0000_0084, "R2 alias 0x84 (1^2=3)");
    look(32'h0000_0044, "R2 0x44 (1^1=0)");
    look(32'h0000_0040, "R2 0x40 row");
  endtask

  task automatic t_band;
    // R5 boundary: correct taken guesses at THETA, THETA+1, and a wrong one.
    upd(32'h0000_0010, 1, THETA, 'h0F);
    look(32'h0000_0010, "R5 at theta trains");
    upd(32'h0000_0010, 1, THETA + 1, 'h0F);
    look(32'h0000_0010, "R5 above theta holds");
    upd(32'h0000_0010, 0, -(THETA + 1), 'h0F);
    look(32'h0000_0010, "R5 confident not-taken holds");
    upd(32'h0000_0010, 1, -(THETA + 1), 'hF0);
    look(32'h0000_0010, "R5 mispredict trains");
    upd(32'h0000_0010, 0, -THETA, 'h55);
    look(32'h0000_0010, "R5 at -theta trains");
  endtask

  task automatic t_snapshot;
    // R6: training must use up_hist, not the live register.
    upd(32'h0000_0020, 1, 0, ~ghr_m & 'hFF);
    look(32'h0000_0020, "R6 uses snapshot history");
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 140; k++) upd(32'h0000_0030, 1, 0, 'hFF);
    look(32'h0000_0030, "R7 positive saturation");
    check("R7 max sum", int'(pred_sum), 9 * 127);
    for (int k = 0; k < 300; k++) upd(32'h0000_0030, 0, 0, 'hFF);
    look(32'h0000_0030, "R7 negative saturation");
    check("R7 min row sum", int'(pred_sum), -128 + 8 * 128);
  endtask

  task automatic t_hist;
    upd(32'h0000_0000, 1, 500, 'h00);
    upd(32'h0000_0000, 0, -500, 'h00);
    upd(32'h0000_0000, 1, 500, 'h00);
    check("R8 shift", int'(pred_hist), ghr_m);
    repeat (3) @(negedge clk);
    check("R8 hold", int'(pred_hist), ghr_m);
    check("R10 theta default", THETA, (193 * HL + 1400) / 100);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) for (int k = 0; k < NW; k++) wm[r][k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_alias();
    t_band();
    t_snapshot();
    t_saturate();
    t_hist();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule